// File: doc/BRIEF.md
# Slave Access Recovery Sequencer

This block sits between a client that wants to read or write a remote slave and a link-level master port. The client presents one access: a byte address inside the slave's 8 MiB space, a size of 1, 2 or 4 bytes, a direction and write data. The block checks the size, the natural alignment and the address range. It folds the two address bits above the 21-bit link address into the slave ID field of the link request. It then issues the access on the master port.

When a link access fails, the block runs a recovery ladder of up to three levels before it retries. The first level reads the remote interrupt-condition and status registers and writes the condition value back to clear it. The second level, used only when the master supports it, sends a terminate command, reads address 0 and repeats the first level. The third level sends a break, rewrites the remote mode register and repeats the first level. An access is attempted at most a fixed number of times. The client receives one response pulse. The pulse carries the read data or an error flag, together with the highest recovery level that was used.

Top module: `slv_recovery_seq`

## Requirements
- R1: `req_size` holds a byte count; only 1, 2 and 4 are legal. Any other value (0, 3, 5, 6, 7) gets an error response with level 0, and no link request, terminate or break is issued.
- R2: Accesses must be naturally aligned: `req_addr[0]` is 0 for size 2, and `req_addr[1:0]` is 0 for size 4. A misaligned request is rejected in the same way as an illegal size.
- R3: An address with bit 23 set is rejected. An address with a nonzero value in bits 22:21 is legal only when `cfg_slave_id` is 0. In that case `m_id` carries bits 22:21; otherwise `m_id` is `cfg_slave_id`. `m_addr` is always address bits 20:0.
- R4: Level 1 recovery uses three size-4 link accesses with ID `cfg_slave_id`: it reads 0x808, reads 0x814, then writes the value read from 0x808 back to 0x808. If all three succeed, recovery is complete.
- R5: If level 1 fails and `cfg_term_ok` is 1, the block pulses `m_term`, reads address 0, and runs level 1 again. Success ends recovery at level 2.
- R6: If level 1 fails and no terminate is available, or any level 2 step fails, the block pulses `m_brk`, writes the mode register at 0x800, and runs level 1 again. Any failure at level 3 ends the access with an error.
- R7: The mode word holds 1 in bit 31 and in bit 29, `cfg_slave_id` in bits 25:24, 0xF in bits 23:20, 0xF in bits 19:16 and 0x8 in bits 11:8. All other bits are 0, so ID 0 gives 0xA0FF0800.
- R8: With `cfg_discard` set, a failed client access reports an error at once, with level 0 and no recovery traffic.
- R9: The client access is issued at most MAX_TRY (2) times. Recovery follows every failed attempt. After a successful recovery on the last attempt, the access reports an error.
- R10: Each accepted request produces exactly one `rsp_valid` pulse, and `req_ready` is high in that cycle. `rsp_rdata` is the link read data for a successful read and 0 for writes and errors. `rsp_level` is the highest recovery level used: 0 none, 1 clear, 2 terminate, 3 break.
- R11: `m_term` and `m_brk` are single-cycle pulses that are never high together. The block waits for the matching done strobe before it continues, and `m_valid` stays high until `m_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slave_id | input | 2 | Configured slave ID |
| cfg_term_ok | input | 1 | Master supports the terminate command |
| cfg_discard | input | 1 | Skip recovery and report failures directly |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 3 | Access size in bytes |
| req_addr | input | 24 | Byte address in slave space |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Access failed or was rejected |
| rsp_rdata | output | 32 | Read data |
| rsp_level | output | 2 | Highest recovery level used |
| m_valid | output | 1 | Link request valid |
| m_ready | input | 1 | Link request accepted |
| m_write | output | 1 | Link request direction |
| m_size | output | 3 | Link request size in bytes |
| m_id | output | 2 | Link slave ID |
| m_addr | output | 21 | Link address |
| m_wdata | output | 32 | Link write data |
| m_done | input | 1 | Link response strobe |
| m_err | input | 1 | Link response error |
| m_rdata | input | 32 | Link read data |
| m_term | output | 1 | Terminate command pulse |
| m_term_done | input | 1 | Terminate complete |
| m_term_err | input | 1 | Terminate failed |
| m_brk | output | 1 | Break command pulse |
| m_brk_done | input | 1 | Break complete |
| m_brk_err | input | 1 | Break failed |

## Verification
The bench builds the block with the default parameters: a 24-bit client address, a 21-bit link address (which leaves a 2-bit folded ID) and two attempts. With these values the fold into all ID codes and the out-of-range bit 23 can both be reached. A per-access failure pattern, driven into the modelled master port, forces every rung of the ladder. This covers a second failed attempt, failed terminate and break commands, and a failed mode write. The bench logs every link access, so it can compare the order of register offsets and the mode word against the requirements.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    OP_MAIN, OP_ISC_RD, OP_STAT_RD, OP_ISC_WR, OP_ZERO_RD, OP_MODE_WR
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_TERM, S_TERM_W, S_BRK, S_BRK_W
  } st_e;

  localparam logic [11:0] REG_MODE = 12'h800;
  localparam logic [11:0] REG_ISC  = 12'h808;
  localparam logic [11:0] REG_STAT = 12'h814;

  localparam logic [3:0] ECHO_DLY  = 4'hF;
  localparam logic [3:0] SEND_DLY  = 4'hF;
  localparam logic [3:0] CLK_RATIO = 4'h8;

  function automatic logic [DW-1:0] mode_word(input logic [1:0] id);
    return {1'b1, 1'b0, 1'b1, 3'b000, id, ECHO_DLY, SEND_DLY, 4'h0, CLK_RATIO, 8'h00};
  endfunction
endpackage

// File: rtl/srs_acc_map.sv
module srs_acc_map #(
  parameter int ADDR_W  = 24,
  parameter int LADDR_W = 21,
  localparam int ID_W   = ADDR_W - 1 - LADDR_W
) (
  input  logic [2:0]         size,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ID_W-1:0]    cfg_id,
  output logic               legal,
  output logic [ID_W-1:0]    map_id,
  output logic [LADDR_W-1:0] map_addr
);
  logic size_ok, in_range, fold, fold_ok;
  logic [ID_W-1:0] hi;

  always_comb begin
    case (size)
      3'd1:    size_ok = 1'b1;
      3'd2:    size_ok = ~addr[0];
      3'd4:    size_ok = (addr[1:0] == 2'b00);
      default: size_ok = 1'b0;
    endcase
  end

  assign in_range = ~addr[ADDR_W-1];
  assign hi       = addr[ADDR_W-2:LADDR_W];
  assign fold     = |hi;
  assign fold_ok  = ~fold | (cfg_id == '0);
  assign legal    = size_ok & in_range & fold_ok;
  assign map_id   = fold ? hi : cfg_id;
  assign map_addr = addr[LADDR_W-1:0];
endmodule

// File: rtl/srs_op_mux.sv
module srs_op_mux
  import srs_pkg::*;
#(
  parameter int LADDR_W = 21,
  parameter int ID_W    = 2
) (
  input  op_e                op,
  input  logic               lat_write,
  input  logic [2:0]         lat_size,
  input  logic [ID_W-1:0]    lat_id,
  input  logic [LADDR_W-1:0] lat_addr,
  input  logic [DW-1:0]      lat_wdata,
  input  logic [ID_W-1:0]    cfg_id,
  input  logic [DW-1:0]      isc_val,
  output logic               m_write,
  output logic [2:0]         m_size,
  output logic [ID_W-1:0]    m_id,
  output logic [LADDR_W-1:0] m_addr,
  output logic [DW-1:0]      m_wdata
);
  always_comb begin
    m_write = 1'b0;
    m_size  = 3'd4;
    m_id    = cfg_id;
    m_addr  = '0;
    m_wdata = '0;
    case (op)
      OP_ISC_RD:  m_addr = LADDR_W'(REG_ISC);
      OP_STAT_RD: m_addr = LADDR_W'(REG_STAT);
      OP_ISC_WR: begin
        m_write = 1'b1;
        m_addr  = LADDR_W'(REG_ISC);
        m_wdata = isc_val;
      end
      OP_ZERO_RD: m_addr = '0;
      OP_MODE_WR: begin
        m_write = 1'b1;
        m_addr  = LADDR_W'(REG_MODE);
        m_wdata = mode_word(2'(cfg_id));
      end
      default: begin
        m_write = lat_write;
        m_size  = lat_size;
        m_id    = lat_id;
        m_addr  = lat_addr;
        m_wdata = lat_wdata;
      end
    endcase
  end
endmodule

// File: rtl/srs_recov_fsm.sv
module srs_recov_fsm
  import srs_pkg::*;
#(
  parameter int MAX_TRY = 2,
  localparam int TRY_W  = $clog2(MAX_TRY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          legal,
  input  logic          lat_write,
  input  logic          cfg_term_ok,
  input  logic          cfg_discard,
  input  logic          m_ready,
  input  logic          m_done,
  input  logic          m_err,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_term_done,
  input  logic          m_term_err,
  input  logic          m_brk_done,
  input  logic          m_brk_err,
  output logic          accept,
  output logic          req_ready,
  output logic          m_valid,
  output logic          m_term,
  output logic          m_brk,
  output op_e           op,
  output logic [DW-1:0] isc_val,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [1:0]    rsp_level
);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRY);
  localparam logic [TRY_W-1:0] TRY_ONE  = TRY_W'(1);

  st_e st, st_n;
  op_e op_n;
  logic [TRY_W-1:0] try_cnt, try_n;
  logic [1:0] lvl_cur, lc_n, lvl_max, lm_n, base;
  logic [DW-1:0] isc_n, fin_data;
  logic fin, fin_err;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_ready & req_valid;
  assign m_valid   = (st == S_REQ);
  assign m_term    = (st == S_TERM);
  assign m_brk     = (st == S_BRK);

  always_comb begin
    st_n = st; op_n = op; try_n = try_cnt; lc_n = lvl_cur; isc_n = isc_val;
    fin = 1'b0; fin_err = 1'b0; fin_data = '0; base = lvl_max;
    case (st)
      S_IDLE: if (req_valid) begin
        base = 2'd0; lc_n = 2'd0; try_n = TRY_ONE;
        if (legal) begin st_n = S_REQ; op_n = OP_MAIN; end
        else begin fin = 1'b1; fin_err = 1'b1; end
      end
      S_REQ: if (m_ready) st_n = S_WAIT;
      S_WAIT: if (m_done) begin
        if (!m_err) begin
          case (op)
            OP_MAIN: begin fin = 1'b1; fin_data = lat_write ? '0 : m_rdata; end
            OP_ISC_RD: begin isc_n = m_rdata; op_n = OP_STAT_RD; st_n = S_REQ; end
            OP_STAT_RD: begin op_n = OP_ISC_WR; st_n = S_REQ; end
            OP_ISC_WR: begin
              if (try_cnt >= TRY_LAST) begin fin = 1'b1; fin_err = 1'b1; end
              else begin
                try_n = try_cnt + TRY_ONE; lc_n = 2'd0; op_n = OP_MAIN; st_n = S_REQ;
              end
            end
            default: begin op_n = OP_ISC_RD; st_n = S_REQ; end
          endcase
        end else begin
          case (op)
            OP_MAIN: begin
              if (cfg_discard) begin fin = 1'b1; fin_err = 1'b1; end
              else begin lc_n = 2'd1; op_n = OP_ISC_RD; st_n = S_REQ; end
            end
            OP_MODE_WR: begin fin = 1'b1; fin_err = 1'b1; end
            default: begin
              if (lvl_cur == 2'd1 && cfg_term_ok) begin lc_n = 2'd2; st_n = S_TERM; end
              else if (lvl_cur != 2'd3) begin lc_n = 2'd3; st_n = S_BRK; end
              else begin fin = 1'b1; fin_err = 1'b1; end
            end
          endcase
        end
      end
      S_TERM: st_n = S_TERM_W;
      S_TERM_W: if (m_term_done) begin
        if (m_term_err) begin lc_n = 2'd3; st_n = S_BRK; end
        else begin op_n = OP_ZERO_RD; st_n = S_REQ; end
      end
      S_BRK: st_n = S_BRK_W;
      S_BRK_W: if (m_brk_done) begin
        if (m_brk_err) begin fin = 1'b1; fin_err = 1'b1; end
        else begin op_n = OP_MODE_WR; st_n = S_REQ; end
      end
      default: st_n = S_IDLE;
    endcase
    if (fin) st_n = S_IDLE;
    lm_n = (lc_n > base) ? lc_n : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_MAIN; try_cnt <= '0; lvl_cur <= '0; lvl_max <= '0;
      isc_val <= '0; rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0; rsp_level <= '0;
    end else begin
      st <= st_n; op <= op_n; try_cnt <= try_n; lvl_cur <= lc_n; lvl_max <= lm_n;
      isc_val <= isc_n;
      rsp_valid <= fin;
      if (fin) begin
        rsp_err <= fin_err; rsp_rdata <= fin_data; rsp_level <= lm_n;
      end
    end
  end

  assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !legal) |=> (!m_valid && !m_term && !m_brk && rsp_valid && rsp_err));
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(op)));
  assert_term_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_term |=> !m_term);
  assert_brk_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_brk |=> !m_brk);
  assert_cmd_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_term && m_brk));
  assert_try_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    try_cnt <= TRY_LAST);
  assert_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && m_done && m_err && op == OP_MAIN && cfg_discard) |=> (rsp_valid && rsp_err));
  assert_mode_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && m_done && m_err && op == OP_MODE_WR) |=> (rsp_valid && rsp_err && rsp_level == 2'd3));
  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
endmodule

// File: rtl/slv_recovery_seq.sv
module slv_recovery_seq
  import srs_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LADDR_W = 21,
  parameter int MAX_TRY = 2,
  localparam int ID_W   = ADDR_W - 1 - LADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    cfg_slave_id,
  input  logic               cfg_term_ok,
  input  logic               cfg_discard,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [2:0]         req_size,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DW-1:0]      rsp_rdata,
  output logic [1:0]         rsp_level,
  output logic               m_valid,
  input  logic               m_ready,
  output logic               m_write,
  output logic [2:0]         m_size,
  output logic [ID_W-1:0]    m_id,
  output logic [LADDR_W-1:0] m_addr,
  output logic [DW-1:0]      m_wdata,
  input  logic               m_done,
  input  logic               m_err,
  input  logic [DW-1:0]      m_rdata,
  output logic               m_term,
  input  logic               m_term_done,
  input  logic               m_term_err,
  output logic               m_brk,
  input  logic               m_brk_done,
  input  logic               m_brk_err
);
  logic [1:0] rst_sync;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic legal, accept;
  logic [ID_W-1:0] map_id, lat_id;
  logic [LADDR_W-1:0] map_addr, lat_addr;
  logic lat_write;
  logic [2:0] lat_size;
  logic [DW-1:0] lat_wdata, isc_val;
  op_e op;

  srs_acc_map #(.ADDR_W(ADDR_W), .LADDR_W(LADDR_W)) u_map (
    .size(req_size), .addr(req_addr), .cfg_id(cfg_slave_id),
    .legal(legal), .map_id(map_id), .map_addr(map_addr));

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      lat_write <= 1'b0; lat_size <= '0; lat_id <= '0; lat_addr <= '0; lat_wdata <= '0;
    end else if (accept) begin
      lat_write <= req_write; lat_size <= req_size; lat_id <= map_id;
      lat_addr <= map_addr; lat_wdata <= req_wdata;
    end
  end

  srs_recov_fsm #(.MAX_TRY(MAX_TRY)) u_fsm (
    .clk(clk), .rst_n(rst_q), .req_valid(req_valid), .legal(legal), .lat_write(lat_write),
    .cfg_term_ok(cfg_term_ok), .cfg_discard(cfg_discard),
    .m_ready(m_ready), .m_done(m_done), .m_err(m_err), .m_rdata(m_rdata),
    .m_term_done(m_term_done), .m_term_err(m_term_err),
    .m_brk_done(m_brk_done), .m_brk_err(m_brk_err),
    .accept(accept), .req_ready(req_ready), .m_valid(m_valid), .m_term(m_term), .m_brk(m_brk),
    .op(op), .isc_val(isc_val),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .rsp_level(rsp_level));

  srs_op_mux #(.LADDR_W(LADDR_W), .ID_W(ID_W)) u_mux (
    .op(op), .lat_write(lat_write), .lat_size(lat_size), .lat_id(lat_id), .lat_addr(lat_addr),
    .lat_wdata(lat_wdata), .cfg_id(cfg_slave_id), .isc_val(isc_val),
    .m_write(m_write), .m_size(m_size), .m_id(m_id), .m_addr(m_addr), .m_wdata(m_wdata));

  assert_fold_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (m_valid && op == OP_MAIN && m_id != cfg_slave_id) |-> (cfg_slave_id == '0));
endmodule

// File: tb/slv_recovery_seq_test.sv
`timescale 1ns/1ps
module slv_recovery_seq_test;
  typedef struct packed {
    logic [2:0] size; logic [23:0] addr; logic wr; logic [1:0] id;
    logic tok; logic disc; logic tf; logic bf; logic [15:0] pat;
    logic eerr; logic [1:0] elvl; logic [7:0] eacc;
    logic [31:0] edata; logic [31:0] emode; logic [3:0] eterm; logic [3:0] ebrk;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{3'd4, 24'h000100, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 8'd1, 32'h00000100, 32'h0, 4'd0, 4'd0},
    '{3'd4, 24'h600104, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 8'd1, 32'hC0000104, 32'h0, 4'd0, 4'd0},
    '{3'd2, 24'h000202, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 8'd1, 32'h40000202, 32'h0, 4'd0, 4'd0},
    '{3'd3, 24'h000100, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 8'd0, 32'h0, 32'h0, 4'd0, 4'd0},
    '{3'd4, 24'h000102, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 8'd0, 32'h0, 32'h0, 4'd0, 4'd0},
    '{3'd4, 24'h200000, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 8'd0, 32'h0, 32'h0, 4'd0, 4'd0},
    '{3'd4, 24'h800000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 8'd0, 32'h0, 32'h0, 4'd0, 4'd0},
    '{3'd4, 24'h000100, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 2'd1, 8'd5, 32'h00000100, 32'h0, 4'd0, 4'd0},
    '{3'd4, 24'h000100, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0001, 1'b1, 2'd0, 8'd1, 32'h0, 32'h0, 4'd0, 4'd0},
    '{3'd4, 24'h000040, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0003, 1'b0, 2'd2, 8'd7, 32'h00000040, 32'h0, 4'd1, 4'd0},
    '{3'd4, 24'h000010, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0003, 1'b0, 2'd3, 8'd7, 32'h40000010, 32'hA1FF0800, 4'd0, 4'd1},
    '{3'd4, 24'h000100, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0011, 1'b1, 2'd1, 8'd8, 32'h0, 32'h0, 4'd0, 4'd0},
    '{3'd4, 24'h000020, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0007, 1'b0, 2'd3, 8'd8, 32'h80000020, 32'hA2FF0800, 4'd1, 4'd1},
    '{3'd4, 24'h000100, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0007, 1'b1, 2'd3, 8'd3, 32'h0, 32'hA0FF0800, 4'd0, 4'd1},
    '{3'd1, 24'h000007, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 8'd1, 32'h0, 32'h0, 4'd0, 4'd0},
    '{3'd4, 24'h000030, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0003, 1'b0, 2'd3, 8'd7, 32'h00000030, 32'hA0FF0800, 4'd1, 4'd1},
    '{3'd4, 24'h000100, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0003, 1'b1, 2'd3, 8'd2, 32'h0, 32'h0, 4'd0, 4'd1},
    '{3'd0, 24'h000100, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 8'd0, 32'h0, 32'h0, 4'd0, 4'd0},
    '{3'd2, 24'h000201, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 8'd0, 32'h0, 32'h0, 4'd0, 4'd0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 2, 5, 6: return "R3";
      3, 17:         return "R1";
      4, 18:         return "R2";
      7:             return "R4";
      8:             return "R8";
      9, 15:         return "R5";
      11:            return "R9";
      14:            return "R10";
      default:       return "R6";
    endcase
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] cfg_slave_id = '0;
  logic cfg_term_ok = 1'b0, cfg_discard = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_size = 3'd4;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = 32'h12345678;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [1:0] rsp_level;
  logic m_valid, m_write, m_term, m_brk;
  logic m_ready = 1'b1;
  logic [2:0] m_size;
  logic [1:0] m_id;
  logic [20:0] m_addr;
  logic [31:0] m_wdata;
  logic m_done = 1'b0, m_err = 1'b0, m_term_done = 1'b0, m_term_err = 1'b0;
  logic m_brk_done = 1'b0, m_brk_err = 1'b0;
  logic [31:0] m_rdata = '0;

  slv_recovery_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_slave_id(cfg_slave_id), .cfg_term_ok(cfg_term_ok),
    .cfg_discard(cfg_discard), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .rsp_level(rsp_level),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_size(m_size), .m_id(m_id),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_done(m_done), .m_err(m_err), .m_rdata(m_rdata),
    .m_term(m_term), .m_term_done(m_term_done), .m_term_err(m_term_err),
    .m_brk(m_brk), .m_brk_done(m_brk_done), .m_brk_err(m_brk_err));

  // Modelled master port: reads return {id, 9'b0, addr}; failures follow cur_pat.
  logic clr = 1'b1;
  logic [15:0] cur_pat = '0;
  logic cur_tf = 1'b0, cur_bf = 1'b0;
  logic [7:0] acc_cnt = '0;
  logic [3:0] term_hi = '0, brk_hi = '0;
  logic pend = 1'b0, p_err = 1'b0;
  logic [31:0] p_data = '0, last_mode = '0;
  logic [20:0] log_addr [16];
  logic log_wr [16];
  logic [31:0] log_data [16];
  logic [2:0] log_size [16];

  always @(posedge clk) begin
    if (clr) begin
      acc_cnt <= '0; pend <= 1'b0; m_done <= 1'b0; m_term_done <= 1'b0; m_brk_done <= 1'b0;
      term_hi <= '0; brk_hi <= '0; last_mode <= '0;
    end else begin
      m_done <= 1'b0; m_term_done <= 1'b0; m_brk_done <= 1'b0;
      if (pend) begin
        m_done <= 1'b1; m_err <= p_err; m_rdata <= p_data; pend <= 1'b0;
      end
      if (m_valid && m_ready) begin
        pend <= 1'b1;
        p_err <= cur_pat[acc_cnt[3:0]];
        p_data <= {m_id, 9'b0, m_addr};
        log_addr[acc_cnt[3:0]] <= m_addr;
        log_wr[acc_cnt[3:0]] <= m_write;
        log_data[acc_cnt[3:0]] <= m_wdata;
        log_size[acc_cnt[3:0]] <= m_size;
        acc_cnt <= acc_cnt + 8'd1;
        if (m_write && m_addr == 21'h800) last_mode <= m_wdata;
      end
      if (m_term) begin term_hi <= term_hi + 4'd1; m_term_done <= 1'b1; m_term_err <= cur_tf; end
      if (m_brk) begin brk_hi <= brk_hi + 4'd1; m_brk_done <= 1'b1; m_brk_err <= cur_bf; end
    end
  end

  int checks = 0, fails = 0;
  logic got, g_err;
  logic [31:0] g_data;
  logic [1:0] g_lvl;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_access(input vec_t v);
    @(negedge clk);
    clr = 1'b1;
    cfg_slave_id = v.id; cfg_term_ok = v.tok; cfg_discard = v.disc;
    cur_pat = v.pat; cur_tf = v.tf; cur_bf = v.bf;
    req_size = v.size; req_addr = v.addr; req_write = v.wr;
    @(negedge clk);
    clr = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 400 && !got; k++) begin
      if (rsp_valid) begin
        got = 1'b1; g_err = rsp_err; g_data = rsp_rdata; g_lvl = rsp_level;
      end else @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // Reset state
    chk("R10", "reset req_ready", 32'(req_ready), 32'd1);
    chk("R10", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R11", "reset m_valid", 32'(m_valid), 32'd0);
    chk("R11", "reset m_term/m_brk", {30'd0, m_term, m_brk}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = tag_of(i);
      do_access(VEC[i]);
      chk(t, $sformatf("v%0d response seen", i), 32'(got), 32'd1);
      chk(t, $sformatf("v%0d rsp_err", i), 32'(g_err), 32'(VEC[i].eerr));
      chk(t, $sformatf("v%0d rsp_level", i), 32'(g_lvl), 32'(VEC[i].elvl));
      chk(t, $sformatf("v%0d rsp_rdata", i), g_data, VEC[i].edata);
      chk(t, $sformatf("v%0d link accesses", i), 32'(acc_cnt), 32'(VEC[i].eacc));
      chk("R11", $sformatf("v%0d terminate pulses", i), 32'(term_hi), 32'(VEC[i].eterm));
      chk("R11", $sformatf("v%0d break pulses", i), 32'(brk_hi), 32'(VEC[i].ebrk));
      if (VEC[i].emode != 32'h0)
        chk("R7", $sformatf("v%0d mode word", i), last_mode, VEC[i].emode);
    end

    // R4: exact order of the level 1 clear sequence
    do_access(VEC[7]);
    chk("R4", "first recovery addr", 32'(log_addr[1]), 32'h808);
    chk("R4", "second recovery addr", 32'(log_addr[2]), 32'h814);
    chk("R4", "clear write addr", 32'(log_addr[3]), 32'h808);
    chk("R4", "clear is write", 32'(log_wr[3]), 32'd1);
    chk("R4", "clear write data", log_data[3], 32'h00000808);
    chk("R4", "recovery size", 32'(log_size[1]), 32'd4);
    chk("R4", "retry addr", 32'(log_addr[4]), 32'h100);

    // R3: folded ID reaches the link with the low 21 bits
    do_access(VEC[1]);
    chk("R3", "folded link addr", 32'(log_addr[0]), 32'h104);

    // R5: terminate followed by read of address 0
    do_access(VEC[9]);
    chk("R5", "read after terminate", 32'(log_addr[2]), 32'h0);

    // R10: write data reaches the link unchanged
    do_access(VEC[14]);
    chk("R10", "write data passed", log_data[0], 32'h12345678);
    chk("R10", "write size passed", 32'(log_size[0]), 32'd1);

    summary();
    $finish;
  end
endmodule